// File: doc/BRIEF.md
# Nibble CPU Conditional Jump Unit

This block is the branch slice of a small 4-bit accumulator processor. It takes one instruction byte per accepted strobe and keeps a 12-bit program counter, a 4-bit accumulator, a carry bit and a condition flip-flop. It acts on four kinds of byte. The load-immediate byte writes its low nibble into the accumulator. The clear-both byte zeroes the accumulator and the carry. The set-carry byte sets the carry, so that the carry tests can be reached. The two-byte conditional jump is the fourth. Every other byte only moves the program counter on.

The first byte of a jump carries a condition nibble. In the cycle that byte is accepted, the nibble is evaluated against the accumulator, the carry and an active-low test pin, and the result is stored in the condition flip-flop. The next accepted byte is the target. If the flip-flop is set, that byte replaces the low eight bits of the program counter, and the upper four bits stay those of the target byte's own address. If it is clear, the counter steps past the target byte. A one-cycle taken flag reports each taken jump, and an active-low condition output shows the flip-flop's value.

Top module: `nibble_jump_unit`

## Requirements
- R1: While rst_n is low, and after it is released, pc is 0, acc is 0, carry is 0, cond_n is 1 and jump_taken is 0.
- R2: An accepted first byte with high nibble 0xD loads its low nibble into acc. For example, 0xD6 gives acc = 6.
- R3: An accepted first byte 0xF0 sets acc to 0 and carry to 0.
- R4: An accepted first byte 0xFA sets carry to 1 and leaves acc unchanged.
- R5: An accepted first byte with high nibble 0x1 is a jump, and its low nibble is the condition. Bit 2 tests acc == 0, bit 1 tests carry == 1 and bit 0 tests test_n == 0. The selected tests are ORed, and bit 3 inverts the result. cond_n shows the inverse of that result from the next cycle and holds it until the next jump byte. For example, 0x14 jumps on a zero acc and 0x1C jumps on a nonzero acc.
- R6: When the flip-flop is set, the byte accepted after a jump byte replaces pc[7:0], and pc[11:8] keeps the page of that byte's own address. jump_taken is 1 for exactly the following cycle.
- R7: When the flip-flop is clear, the byte accepted after a jump byte only advances pc by one, and jump_taken stays 0.
- R8: Every accepted byte that is not a taken target advances pc by one, wrapping modulo 4096. Bytes outside R2 to R5 change neither acc nor carry.
- R9: A cycle with instr_vld low changes nothing, and jump_taken is 0 in the cycle that follows it.
- R10: No output carries an unknown value after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_byte | input | 8 | Instruction or target byte |
| instr_vld | input | 1 | instr_byte is accepted on this edge |
| test_n | input | 1 | Test pin, active low, sampled with a jump's first byte |
| pc | output | 12 | Address of the next byte expected |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry bit |
| cond_n | output | 1 | Inverse of the condition flip-flop; low means the pending jump is taken |
| jump_taken | output | 1 | One-cycle pulse after a taken jump's target is loaded |

## Verification
The assertions assume that the byte accepted after a jump byte is always its target. They also assume that test_n and instr_byte are stable and known at each rising edge where instr_vld is high. The bench meets both assumptions because it changes inputs only on falling edges. It also tracks in its own model whether a target is pending, so that its random choice of opcode applies only to first bytes, while the target byte it sends is free random data. Random idle cycles and a random test pin are mixed in. Page crossings are reached both by counting past a page end and by a directed jump placed on the last address of a page.

// File: rtl/nj_pkg.sv
package nj_pkg;

   typedef enum logic [2:0] {
      K_NOP = 3'd0,
      K_LDI = 3'd1,
      K_CLB = 3'd2,
      K_STC = 3'd3,
      K_JCN = 3'd4
   } kind_e;

   localparam logic [3:0] HI_LDI   = 4'hD;
   localparam logic [3:0] HI_JCN   = 4'h1;
   localparam logic [7:0] BYTE_CLB = 8'hF0;
   localparam logic [7:0] BYTE_STC = 8'hFA;

endpackage

// File: rtl/nj_decode.sv
module nj_decode
   import nj_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] byte_in,
   output kind_e             kind
);
   localparam int NIB_W = BYTE_W / 2;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("nj_decode: BYTE_W must be 8");
   end

   logic [NIB_W-1:0] hi;
   assign hi = byte_in[BYTE_W-1:NIB_W];

   always_comb begin
      kind = K_NOP;
      if (hi == HI_LDI)             kind = K_LDI;
      else if (hi == HI_JCN)        kind = K_JCN;
      else if (byte_in == BYTE_CLB) kind = K_CLB;
      else if (byte_in == BYTE_STC) kind = K_STC;
   end
endmodule

// File: rtl/nj_cond_eval.sv
module nj_cond_eval #(
   parameter int NIB_W = 4
) (
   input  logic [NIB_W-1:0] cond_nib,
   input  logic [NIB_W-1:0] acc_in,
   input  logic             carry_in,
   input  logic             test_n_in,
   output logic             take
);
   localparam int N_TEST  = 3;
   localparam int INV_BIT = NIB_W - 1;

   if (NIB_W <= N_TEST) begin : g_bad_nib
      $error("nj_cond_eval: NIB_W must exceed the test count");
   end

   logic [N_TEST-1:0] src;
   logic [N_TEST-1:0] hit;

   assign src[0] = ~test_n_in;
   assign src[1] = carry_in;
   assign src[2] = (acc_in == '0);

   for (genvar i = 0; i < N_TEST; i++) begin : g_hit
      assign hit[i] = cond_nib[i] & src[i];
   end

   assign take = (|hit) ^ cond_nib[INV_BIT];
endmodule

// File: rtl/nj_pc.sv
module nj_pc #(
   parameter int ADDR_W = 12,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [PAGE_W-1:0] low_in,
   output logic [ADDR_W-1:0] pc_q
);
   logic [ADDR_W-1:0] target;

   if (ADDR_W > PAGE_W) begin : g_paged
      assign target = {pc_q[ADDR_W-1:PAGE_W], low_in};
   end else begin : g_flat
      assign target = low_in[ADDR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pc_q <= '0;
      else if (load) pc_q <= target;
      else if (step) pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/nibble_jump_unit.sv
module nibble_jump_unit
   import nj_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NIB_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*NIB_W-1:0]   instr_byte,
   input  logic                 instr_vld,
   input  logic                 test_n,
   output logic [ADDR_W-1:0]    pc,
   output logic [NIB_W-1:0]     acc,
   output logic                 carry,
   output logic                 cond_n,
   output logic                 jump_taken
);
   localparam int BYTE_W = 2 * NIB_W;

   if (NIB_W != 4) begin : g_bad_nib
      $error("nibble_jump_unit: NIB_W must be 4");
   end
   if (ADDR_W <= BYTE_W) begin : g_bad_addr
      $error("nibble_jump_unit: ADDR_W must exceed one byte");
   end

   kind_e            kind;
   logic             take_now;
   logic             operand_q;
   logic             cff_q;
   logic             carry_q;
   logic             jt_q;
   logic [NIB_W-1:0] acc_q;
   logic             accept_op;
   logic             accept_tgt;

   assign accept_op  = instr_vld & ~operand_q;
   assign accept_tgt = instr_vld & operand_q;

   nj_decode #(.BYTE_W(BYTE_W)) u_dec (
      .byte_in (instr_byte),
      .kind    (kind)
   );

   nj_cond_eval #(.NIB_W(NIB_W)) u_cond (
      .cond_nib  (instr_byte[NIB_W-1:0]),
      .acc_in    (acc_q),
      .carry_in  (carry_q),
      .test_n_in (test_n),
      .take      (take_now)
   );

   nj_pc #(.ADDR_W(ADDR_W), .PAGE_W(BYTE_W)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (accept_op | (accept_tgt & ~cff_q)),
      .load   (accept_tgt & cff_q),
      .low_in (instr_byte),
      .pc_q   (pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         carry_q   <= 1'b0;
         cff_q     <= 1'b0;
         operand_q <= 1'b0;
         jt_q      <= 1'b0;
      end else begin
         jt_q <= 1'b0;
         if (accept_op) begin
            case (kind)
               K_LDI: acc_q <= instr_byte[NIB_W-1:0];
               K_CLB: begin
                  acc_q   <= '0;
                  carry_q <= 1'b0;
               end
               K_STC: carry_q <= 1'b1;
               K_JCN: begin
                  cff_q     <= take_now;
                  operand_q <= 1'b1;
               end
               default: ;
            endcase
         end
         if (accept_tgt) begin
            operand_q <= 1'b0;
            jt_q      <= cff_q;
         end
      end
   end

   assign acc        = acc_q;
   assign carry      = carry_q;
   assign cond_n     = ~cff_q;
   assign jump_taken = jt_q;
endmodule

// File: rtl/nj_chk.sv
module nj_chk #(
   parameter int ADDR_W = 12,
   parameter int NIB_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2*NIB_W-1:0] instr_byte,
   input logic               instr_vld,
   input logic               test_n,
   input logic [ADDR_W-1:0]  pc,
   input logic [NIB_W-1:0]   acc,
   input logic               carry,
   input logic               cond_n,
   input logic               jump_taken,
   input logic               operand_pending
);
   localparam int BYTE_W = 2 * NIB_W;

   logic first_vld;
   assign first_vld = instr_vld && !operand_pending;

   p_ldi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (first_vld && instr_byte[BYTE_W-1:NIB_W] == 4'hD)
      |=> (acc == $past(instr_byte[NIB_W-1:0]) && pc == $past(pc) + 1'b1));

   p_clb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (first_vld && instr_byte == 8'hF0) |=> (acc == '0 && !carry));

   p_stc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (first_vld && instr_byte == 8'hFA) |=> (carry && $stable(acc)));

   p_cond_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(first_vld && instr_byte[BYTE_W-1:NIB_W] == 4'h1) |=> $stable(cond_n));

   p_taken_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
      jump_taken |-> (pc[BYTE_W-1:0] == $past(instr_byte)
                      && pc[ADDR_W-1:BYTE_W] == $past(pc[ADDR_W-1:BYTE_W])));

   p_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_vld && operand_pending && cond_n)
      |=> (!jump_taken && pc == $past(pc) + 1'b1));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_vld |=> ($stable(pc) && $stable(acc) && $stable(carry)
                      && $stable(cond_n) && !jump_taken));

   p_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({pc, acc, carry, cond_n, jump_taken}));
endmodule

bind nibble_jump_unit nj_chk #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .instr_byte      (instr_byte),
   .instr_vld       (instr_vld),
   .test_n          (test_n),
   .pc              (pc),
   .acc             (acc),
   .carry           (carry),
   .cond_n          (cond_n),
   .jump_taken      (jump_taken),
   .operand_pending (operand_q)
);

// File: tb/sim_nibble_jump_unit.sv
module sim_nibble_jump_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;
   localparam int N_RAND     = 4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  instr_byte = 8'h00;
   logic        instr_vld = 1'b0;
   logic        test_n = 1'b1;
   logic [11:0] pc;
   logic [3:0]  acc;
   logic        carry;
   logic        cond_n;
   logic        jump_taken;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [11:0] m_pc = '0;
   logic [3:0]  m_acc = '0;
   logic        m_c = 1'b0;
   logic        m_cff = 1'b0;
   logic        m_op = 1'b0;
   logic        m_jt = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nibble_jump_unit u0 (
      .clk(clk), .rst_n(rst_n), .instr_byte(instr_byte), .instr_vld(instr_vld),
      .test_n(test_n), .pc(pc), .acc(acc), .carry(carry), .cond_n(cond_n),
      .jump_taken(jump_taken)
   );

   function automatic logic f_cond(input logic [3:0] nib, input logic [3:0] a,
                                   input logic c, input logic tn);
      logic any;
      any = (nib[2] && a == 4'd0) || (nib[1] && c) || (nib[0] && !tn);
      return any ^ nib[3];
   endfunction

   task automatic check(input string tag);
      total++;
      if ($isunknown({pc, acc, carry, cond_n, jump_taken}) ||
          pc !== m_pc || acc !== m_acc || carry !== m_c ||
          cond_n !== !m_cff || jump_taken !== m_jt) begin
         bad++;
         $display("FAIL %s actual pc=%h acc=%h c=%b cn=%b jt=%b expected pc=%h acc=%h c=%b cn=%b jt=%b",
                  tag, pc, acc, carry, cond_n, jump_taken,
                  m_pc, m_acc, m_c, !m_cff, m_jt);
      end
   endtask

   task automatic send(input logic [7:0] b, input logic tn, input logic v);
      string tag;
      instr_byte = b;
      test_n     = tn;
      instr_vld  = v;
      @(posedge clk);
      m_jt = 1'b0;
      if (!v) tag = "R9 idle";
      else if (m_op) begin
         m_op = 1'b0;
         if (m_cff) begin
            m_pc = {m_pc[11:8], b};
            m_jt = 1'b1;
            tag  = "R6 taken target";
         end else begin
            m_pc = m_pc + 12'd1;
            tag  = "R7 skipped target";
         end
      end else begin
         m_pc = m_pc + 12'd1;
         if (b[7:4] == 4'hD) begin
            m_acc = b[3:0];
            tag   = "R2 load";
         end else if (b[7:4] == 4'h1) begin
            m_cff = f_cond(b[3:0], m_acc, m_c, tn);
            m_op  = 1'b1;
            tag   = "R5 condition";
         end else if (b == 8'hF0) begin
            m_acc = 4'd0;
            m_c   = 1'b0;
            tag   = "R3 clear";
         end else if (b == 8'hFA) begin
            m_c = 1'b1;
            tag = "R4 set carry";
         end else tag = "R8 other byte";
      end
      @(negedge clk);
      check(tag);
   endtask

   function automatic logic [7:0] rand_first();
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
         0, 1:    return {4'hD, 4'($urandom_range(0, 15))};
         2:       return 8'hF0;
         3:       return 8'hFA;
         4, 5, 6: return {4'h1, 4'($urandom_range(0, 15))};
         default: return 8'($urandom_range(0, 255));
      endcase
   endfunction

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset held");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset released");
      check("R10 known");

      // step to 0x00D with plain bytes (R8)
      for (int i = 0; i < 13; i++) send(8'h00, 1'b1, 1'b1);
      // directed jump program
      send(8'hD6, 1'b1, 1'b1);                         // R2 acc=6
      send(8'h14, 1'b1, 1'b1); send(8'h13, 1'b1, 1'b1); // R7 zero test false
      send(8'h1C, 1'b1, 1'b1); send(8'h13, 1'b1, 1'b1); // R6 to 0x013
      send(8'hF0, 1'b1, 1'b1);                          // R3
      send(8'h1C, 1'b1, 1'b1); send(8'h19, 1'b1, 1'b1); // R7
      send(8'h14, 1'b1, 1'b1); send(8'h19, 1'b1, 1'b1); // R6 to 0x019
      // carry tests (R4, R5)
      send(8'hFA, 1'b1, 1'b1);
      send(8'h12, 1'b1, 1'b1); send(8'h30, 1'b1, 1'b1); // taken
      send(8'h1A, 1'b1, 1'b1); send(8'h40, 1'b1, 1'b1); // inverted: not taken
      send(8'hF0, 1'b1, 1'b1);
      send(8'h12, 1'b1, 1'b1); send(8'h50, 1'b1, 1'b1); // carry clear: not taken
      // test pin (R5)
      send(8'h11, 1'b0, 1'b1); send(8'h60, 1'b1, 1'b1); // taken
      send(8'h11, 1'b1, 1'b1); send(8'h70, 1'b1, 1'b1); // not taken
      send(8'h19, 1'b1, 1'b1); send(8'h80, 1'b1, 1'b1); // inverted: taken
      send(8'h10, 1'b0, 1'b1); send(8'h90, 1'b1, 1'b1); // no test: never
      // idle cycles in the middle of a jump (R9)
      send(8'h18, 1'b1, 1'b1);
      send(8'h55, 1'b0, 1'b0);
      send(8'h55, 1'b0, 1'b0);
      send(8'hFF, 1'b1, 1'b1);                          // R6 to 0x0FF
      // jump on the last address of a page: target in the next page (R6)
      send(8'h18, 1'b1, 1'b1); send(8'h05, 1'b1, 1'b1); // expect 0x105

      for (int i = 0; i < N_RAND; i++) begin
         logic tn;
         logic v;
         tn = 1'($urandom_range(0, 1));
         v  = ($urandom_range(0, 4) != 0);
         if (m_op) send(8'($urandom_range(0, 255)), tn, v);
         else      send(rand_first(), tn, v);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule